// File: doc/BRIEF.md
# High-Side Channel Fault and Retry Controller

This block decides, for every output channel of a multi-channel high-side switch, whether the gate driver may conduct. It first builds a per-channel switch-on request. The request comes from the parallel pin, a software on bit, a pin-enable bit, a global PWM enable and the channel's duty-cycle phase. The block then weighs that request against digital fault flags from the analog detectors.

Severe shorts and over-temperature shut the channel down until software clears it. An overcurrent event turns the channel off for a programmable retry period and then lets it try again. Each such retry is counted, and when the configured retry limit is reached the channel shuts down for good, unless unlimited retries are selected. Overvoltage holds every channel off until the condition has gone and a full retry period has elapsed. Open-load and short-to-supply flags only set sticky status bits. All status bits and an active-low summary fault flag are registered outputs, for readback over the serial interface.

Top module: `hsf_ctrl`

## Requirements
- R1: With no fault flags active, `gate_en[i]` one clock after the inputs equals ((`par_in[i]` AND `in_en[i]`) OR `on_bit[i]`) AND `pwm_en`, ORed with (`on_bit[i]` AND `duty_ph[i]` AND `pwm_en`).
- R2: `sev_short[i]` while channel i is requested on latches the channel off. It sets `st_latched[i]` and `st_sc[i]`, and `fault_n` goes low. The same flag while the channel is requested off has no effect.
- R3: `over_temp[i]` while channel i is requested on latches the channel off and sets `st_latched[i]` and `st_ot[i]`.
- R4: `over_cur[i]` while channel i is on turns the channel off and sets `st_oc[i]`. After a single-cycle event, `gate_en[i]` reads low for max(`retry_ticks`,1)+1 samples and then returns to the request.
- R5: With `unlim_retry[i]`=0, the 16th overcurrent retry since the last clear latches the channel off and drives `fault_n` low. The first 15 retries do not.
- R6: With `unlim_retry[i]`=1, no number of overcurrent retries latches the channel.
- R7: `over_volt` with `ov_dis`=0 turns every channel off and sets `st_ov`. After the flag drops, a requested channel stays off for max(`retry_ticks`,1) samples and then resumes. With `ov_dis`=1, `over_volt` has no effect on the gates.
- R8: A one-cycle pulse on `fault_clr` or `leave_fs` clears the latched state, the retry counter and all status bits. Requested channels turn back on two clocks later.
- R9: After reset `gate_en` and all status outputs are 0 and `fault_n` is 1.
- R10: `ol_on[i]` while the gate is on sets `st_olon[i]`. `ol_off[i]` or `sh_supply[i]` while the channel is requested off sets `st_oloff[i]` or `st_shsup[i]`. None of these changes a gate.
- R11: `fault_n` is low exactly one clock after any bit of `st_latched` is set, and high one clock after none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | NCH | Parallel control pins |
| in_en | input | NCH | Pin path enable per channel |
| on_bit | input | NCH | Software on request |
| duty_ph | input | NCH | Duty-cycle phase from PWM generator |
| pwm_en | input | 1 | Global output enable |
| unlim_retry | input | NCH | 1 removes the retry limit |
| ov_dis | input | 1 | 1 ignores overvoltage |
| retry_ticks | input | TW | Retry period in clocks (0 acts as 1) |
| fault_clr | input | 1 | Clear pulse from a software write |
| leave_fs | input | 1 | Clear pulse on return to normal mode |
| sev_short | input | NCH | Severe short-circuit flags |
| over_cur | input | NCH | Overcurrent flags |
| over_temp | input | NCH | Over-temperature flags |
| over_volt | input | 1 | Supply overvoltage flag |
| ol_on | input | NCH | Open load in on state |
| ol_off | input | NCH | Open load in off state |
| sh_supply | input | NCH | Output shorted to supply |
| gate_en | output | NCH | Gate drive enable |
| fault_n | output | 1 | Active-low summary fault |
| st_latched | output | NCH | Channel latched off |
| st_sc | output | NCH | Severe short status |
| st_ot | output | NCH | Over-temperature status |
| st_oc | output | NCH | Overcurrent status |
| st_ov | output | NCH | Overvoltage seen |
| st_olon | output | NCH | Open load on status |
| st_oloff | output | NCH | Open load off status |
| st_shsup | output | NCH | Short to supply status |

## Verification
Some properties are checked by assertions on every cycle:
- a latched channel never drives its gate;
- short and over-temperature status bits only exist alongside a latch;
- a clear pulse empties the latches;
- active overvoltage forces all gates low in the next cycle;
- the summary flag tracks the latch vector with one clock of delay;
- a gate only rises after `pwm_en` was high.

Other behaviour depends on history and can only be shown by the bench's scenarios. This covers the exact length of the off window for each retry period, the count at which retries turn into a latch, the absence of any latch with unlimited retries, and the full truth-table sweep of the request logic.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  typedef enum logic [1:0] {
    CH_RUN   = 2'd0,
    CH_RETRY = 2'd1,
    CH_LATCH = 2'd2
  } ch_state_t;
endpackage

// File: rtl/hsf_cmd.sv
module hsf_cmd #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] par_in,
  input  logic [NCH-1:0] in_en,
  input  logic [NCH-1:0] on_bit,
  input  logic [NCH-1:0] duty_ph,
  input  logic           pwm_en,
  output logic [NCH-1:0] cmd
);
  for (genvar g = 0; g < NCH; g++) begin : g_req
    always_comb begin
      cmd[g] = (((par_in[g] & in_en[g]) | on_bit[g]) & pwm_en)
             | (on_bit[g] & duty_ph[g] & pwm_en);
    end
  end
endmodule

// File: rtl/hsf_chan.sv
module hsf_chan
  import hsf_pkg::*;
#(
  parameter int TW          = 8,
  parameter int RETRY_LIMIT = 16,
  localparam int CW = $clog2(RETRY_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cmd,
  input  logic          sc,
  input  logic          oc,
  input  logic          ot,
  input  logic          ov_act,
  input  logic          ol_on,
  input  logic          ol_off,
  input  logic          shsup,
  input  logic          unlim,
  input  logic [TW-1:0] period,
  output logic          gate,
  output logic          lat,
  output logic          s_sc,
  output logic          s_ot,
  output logic          s_oc,
  output logic          s_ov,
  output logic          s_olon,
  output logic          s_oloff,
  output logic          s_shsup
);
  ch_state_t     st, st_n;
  logic [TW-1:0] tmr, tmr_n;
  logic [CW-1:0] cnt, cnt_n, cnt_inc;
  logic          gate_n;
  logic          run_sc, run_ot, run_oc;

  assign cnt_inc = cnt + CW'(1);
  assign run_sc  = (st == CH_RUN) & cmd & sc;
  assign run_ot  = (st == CH_RUN) & cmd & ot & ~sc;
  assign run_oc  = (st == CH_RUN) & cmd & oc & ~sc & ~ot;

  always_comb begin
    st_n   = st;
    tmr_n  = tmr;
    cnt_n  = cnt;
    gate_n = 1'b0;
    case (st)
      CH_RUN: begin
        if (run_sc || run_ot) begin
          st_n = CH_LATCH;
        end else if (run_oc) begin
          tmr_n = '0;
          if (unlim) begin
            st_n = CH_RETRY;
          end else begin
            cnt_n = cnt_inc;
            st_n  = (cnt_inc >= CW'(RETRY_LIMIT)) ? CH_LATCH : CH_RETRY;
          end
        end else if (ov_act) begin
          st_n  = CH_RETRY;
          tmr_n = '0;
        end else begin
          gate_n = cmd;
        end
      end
      CH_RETRY: begin
        if (ov_act) begin
          tmr_n = '0;
        end else if (({1'b0, tmr} + (TW+1)'(1)) >= {1'b0, period}) begin
          st_n  = CH_RUN;
          tmr_n = '0;
        end else begin
          tmr_n = tmr + TW'(1);
        end
      end
      default: st_n = CH_LATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st      <= CH_RUN;
      tmr     <= '0;
      cnt     <= '0;
      gate    <= 1'b0;
      s_sc    <= 1'b0;
      s_ot    <= 1'b0;
      s_oc    <= 1'b0;
      s_ov    <= 1'b0;
      s_olon  <= 1'b0;
      s_oloff <= 1'b0;
      s_shsup <= 1'b0;
    end else begin
      st      <= st_n;
      tmr     <= tmr_n;
      cnt     <= cnt_n;
      gate    <= gate_n;
      s_sc    <= s_sc | run_sc;
      s_ot    <= s_ot | run_ot;
      s_oc    <= s_oc | run_oc;
      s_ov    <= s_ov | ov_act;
      s_olon  <= s_olon | (gate & ol_on);
      s_oloff <= s_oloff | (~cmd & ol_off);
      s_shsup <= s_shsup | (~cmd & shsup);
    end
  end

  assign lat = (st == CH_LATCH);
endmodule

// File: rtl/hsf_ctrl.sv
module hsf_ctrl #(
  parameter int NCH         = 4,
  parameter int TW          = 8,
  parameter int RETRY_LIMIT = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] par_in,
  input  logic [NCH-1:0] in_en,
  input  logic [NCH-1:0] on_bit,
  input  logic [NCH-1:0] duty_ph,
  input  logic           pwm_en,
  input  logic [NCH-1:0] unlim_retry,
  input  logic           ov_dis,
  input  logic [TW-1:0]  retry_ticks,
  input  logic           fault_clr,
  input  logic           leave_fs,
  input  logic [NCH-1:0] sev_short,
  input  logic [NCH-1:0] over_cur,
  input  logic [NCH-1:0] over_temp,
  input  logic           over_volt,
  input  logic [NCH-1:0] ol_on,
  input  logic [NCH-1:0] ol_off,
  input  logic [NCH-1:0] sh_supply,
  output logic [NCH-1:0] gate_en,
  output logic           fault_n,
  output logic [NCH-1:0] st_latched,
  output logic [NCH-1:0] st_sc,
  output logic [NCH-1:0] st_ot,
  output logic [NCH-1:0] st_oc,
  output logic [NCH-1:0] st_ov,
  output logic [NCH-1:0] st_olon,
  output logic [NCH-1:0] st_oloff,
  output logic [NCH-1:0] st_shsup
);
  logic [NCH-1:0] cmd;
  logic           clr_any;
  logic           ov_act;

  assign clr_any = fault_clr | leave_fs;
  assign ov_act  = over_volt & ~ov_dis;

  hsf_cmd #(.NCH(NCH)) u_cmd (
    .par_in (par_in),
    .in_en  (in_en),
    .on_bit (on_bit),
    .duty_ph(duty_ph),
    .pwm_en (pwm_en),
    .cmd    (cmd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hsf_chan #(.TW(TW), .RETRY_LIMIT(RETRY_LIMIT)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_any),
      .cmd    (cmd[g]),
      .sc     (sev_short[g]),
      .oc     (over_cur[g]),
      .ot     (over_temp[g]),
      .ov_act (ov_act),
      .ol_on  (ol_on[g]),
      .ol_off (ol_off[g]),
      .shsup  (sh_supply[g]),
      .unlim  (unlim_retry[g]),
      .period (retry_ticks),
      .gate   (gate_en[g]),
      .lat    (st_latched[g]),
      .s_sc   (st_sc[g]),
      .s_ot   (st_ot[g]),
      .s_oc   (st_oc[g]),
      .s_ov   (st_ov[g]),
      .s_olon (st_olon[g]),
      .s_oloff(st_oloff[g]),
      .s_shsup(st_shsup[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fault_n <= 1'b1;
    else     fault_n <= ~|st_latched;
  end
endmodule

// File: rtl/hsf_ctrl_chk.sv
module hsf_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           pwm_en,
  input logic           ov_dis,
  input logic           over_volt,
  input logic           fault_clr,
  input logic           leave_fs,
  input logic [NCH-1:0] gate_en,
  input logic           fault_n,
  input logic [NCH-1:0] st_latched,
  input logic [NCH-1:0] st_sc,
  input logic [NCH-1:0] st_ot
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    assert_latch_gate_off_R2: assert property (@(posedge clk) disable iff (rst)
      st_latched[g] |-> !gate_en[g]);
    assert_sc_implies_latch_R2: assert property (@(posedge clk) disable iff (rst)
      st_sc[g] |-> st_latched[g]);
    assert_ot_implies_latch_R3: assert property (@(posedge clk) disable iff (rst)
      st_ot[g] |-> st_latched[g]);
    assert_gate_needs_pwm_R1: assert property (@(posedge clk) disable iff (rst)
      gate_en[g] |-> $past(pwm_en));
  end

  assert_flag_low_R11: assert property (@(posedge clk) disable iff (rst)
    (|st_latched) |=> !fault_n);
  assert_flag_high_R11: assert property (@(posedge clk) disable iff (rst)
    !(|st_latched) |=> fault_n);
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_clr || leave_fs) |=> (st_latched == '0 && st_sc == '0 && st_ot == '0));
  assert_ov_forces_off_R7: assert property (@(posedge clk) disable iff (rst)
    (over_volt && !ov_dis) |=> (gate_en == '0));
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (gate_en == '0 && fault_n && st_latched == '0));
endmodule

bind hsf_ctrl hsf_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwm_en    (pwm_en),
  .ov_dis    (ov_dis),
  .over_volt (over_volt),
  .fault_clr (fault_clr),
  .leave_fs  (leave_fs),
  .gate_en   (gate_en),
  .fault_n   (fault_n),
  .st_latched(st_latched),
  .st_sc     (st_sc),
  .st_ot     (st_ot)
);

// File: tb/sim_hsf_ctrl.sv
module sim_hsf_ctrl;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int TW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] par_in = '0, in_en = '0, on_bit = '0, duty_ph = '0;
  logic pwm_en = 1'b0;
  logic [NCH-1:0] unlim_retry = '0;
  logic ov_dis = 1'b0;
  logic [TW-1:0] retry_ticks = 8'd2;
  logic fault_clr = 1'b0, leave_fs = 1'b0;
  logic [NCH-1:0] sev_short = '0, over_cur = '0, over_temp = '0;
  logic over_volt = 1'b0;
  logic [NCH-1:0] ol_on = '0, ol_off = '0, sh_supply = '0;
  logic [NCH-1:0] gate_en, st_latched, st_sc, st_ot, st_oc, st_ov;
  logic [NCH-1:0] st_olon, st_oloff, st_shsup;
  logic fault_n;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hsf_ctrl #(.NCH(NCH), .TW(TW)) u0 (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_pulse();
    fault_clr = 1'b1; tick(); fault_clr = 1'b0; tick(); tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int n;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R9 reset state
    chk("R9 gate", int'(gate_en), 0);
    chk("R9 fault_n", int'(fault_n), 1);
    chk("R9 status", int'(st_latched | st_sc | st_oc | st_ov | st_olon), 0);

    // R1 request truth table sweep
    for (int v = 0; v < 32; v++) begin
      logic [NCH-1:0] exp_g;
      pwm_en = v[4];
      for (int i = 0; i < NCH; i++) begin
        int w;
        w = (v + i * 5) & 15;
        par_in[i] = w[0]; in_en[i] = w[1]; on_bit[i] = w[2]; duty_ph[i] = w[3];
        exp_g[i] = (((w[0] & w[1]) | w[2]) & v[4]) | (w[2] & w[3] & v[4]);
      end
      tick();
      chk("R1 request", int'(gate_en), int'(exp_g));
    end

    // all channels on by software bit
    par_in = '0; in_en = '0; duty_ph = '0; on_bit = '1; pwm_en = 1'b1;
    tick();
    chk("R1 all on", int'(gate_en), 15);

    // R2 severe short while on
    sev_short[0] = 1'b1; tick(); sev_short[0] = 1'b0; tick();
    chk("R2 gate off", int'(gate_en[0]), 0);
    chk("R2 latched", int'(st_latched[0]), 1);
    chk("R2 sc bit", int'(st_sc[0]), 1);
    chk("R2 fault_n", int'(fault_n), 0);
    // R2 short while requested off is ignored
    on_bit[1] = 1'b0; tick();
    sev_short[1] = 1'b1; tick(); sev_short[1] = 1'b0; tick();
    chk("R2 off short ignored", int'(st_latched[1] | st_sc[1]), 0);
    on_bit[1] = 1'b1;
    // R8 clear by write
    clear_pulse();
    chk("R8 clear latch", int'(st_latched | st_sc), 0);
    chk("R8 gate back", int'(gate_en), 15);
    chk("R11 flag back", int'(fault_n), 1);

    // R3 over-temperature
    over_temp[2] = 1'b1; tick(); over_temp[2] = 1'b0; tick();
    chk("R3 latched", int'(st_latched[2]), 1);
    chk("R3 ot bit", int'(st_ot[2]), 1);
    chk("R3 gate", int'(gate_en[2]), 0);
    chk("R3 others", int'(gate_en), 11);
    // R8 clear by mode exit
    leave_fs = 1'b1; tick(); leave_fs = 1'b0; tick(); tick();
    chk("R8 mode exit", int'(st_latched | st_ot), 0);
    chk("R8 mode exit gate", int'(gate_en), 15);

    // R4 overcurrent off window for several periods
    for (int p = 0; p < 6; p++) begin
      retry_ticks = TW'(p);
      over_cur[1] = 1'b1; tick(); over_cur[1] = 1'b0;
      n = gate_en[1] ? 0 : 1;
      for (int k = 0; k < 20; k++) begin
        tick();
        if (gate_en[1]) break;
        n++;
      end
      chk("R4 off window", n, ((p < 1) ? 1 : p) + 1);
      chk("R4 oc bit", int'(st_oc[1]), 1);
      clear_pulse();
    end

    // R5 counted retries latch at 16
    retry_ticks = 8'd2; unlim_retry = '0;
    for (int r = 1; r <= 16; r++) begin
      over_cur[3] = 1'b1; tick(); over_cur[3] = 1'b0;
      repeat (6) tick();
      if (r == 15) begin
        chk("R5 not latched at 15", int'(st_latched[3]), 0);
        chk("R5 gate on at 15", int'(gate_en[3]), 1);
      end
    end
    chk("R5 latched at 16", int'(st_latched[3]), 1);
    chk("R5 gate off", int'(gate_en[3]), 0);
    chk("R5 fault_n", int'(fault_n), 0);
    clear_pulse();

    // R6 unlimited retries
    unlim_retry[3] = 1'b1;
    for (int r = 1; r <= 20; r++) begin
      over_cur[3] = 1'b1; tick(); over_cur[3] = 1'b0;
      repeat (6) tick();
    end
    chk("R6 never latched", int'(st_latched[3]), 0);
    chk("R6 gate on", int'(gate_en[3]), 1);
    chk("R6 fault_n", int'(fault_n), 1);
    clear_pulse();

    // R7 overvoltage
    for (int p = 1; p < 5; p += 2) begin
      retry_ticks = TW'(p);
      over_volt = 1'b1; repeat (5) tick();
      chk("R7 all off", int'(gate_en), 0);
      chk("R7 ov bits", int'(st_ov), 15);
      over_volt = 1'b0;
      n = 0;
      for (int k = 0; k < 20; k++) begin
        tick();
        if (gate_en[0]) break;
        n++;
      end
      chk("R7 resume delay", n, p);
      clear_pulse();
    end
    ov_dis = 1'b1; over_volt = 1'b1; repeat (3) tick();
    chk("R7 disabled", int'(gate_en), 15);
    over_volt = 1'b0; ov_dis = 1'b0; tick();

    // R10 diagnostics only
    ol_on[0] = 1'b1; ol_off[1] = 1'b1; tick(); ol_on[0] = 1'b0; ol_off[1] = 1'b0; tick();
    chk("R10 olon set", int'(st_olon[0]), 1);
    chk("R10 oloff ignored when on", int'(st_oloff[1]), 0);
    chk("R10 gates kept", int'(gate_en), 15);
    on_bit[2] = 1'b0; tick();
    ol_off[2] = 1'b1; sh_supply[2] = 1'b1; tick(); ol_off[2] = 1'b0; sh_supply[2] = 1'b0; tick();
    chk("R10 oloff", int'(st_oloff[2]), 1);
    chk("R10 shsup", int'(st_shsup[2]), 1);
    chk("R10 no latch", int'(st_latched), 0);
    chk("R10 gates", int'(gate_en), 11);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule